// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects interrupt requests from eight peripheral lines and reports one of them to a processor. Each line is watched for a low-to-high transition, which latches a pending bit. A mask register can hold back any line. A fixed-priority resolver weighs the unmasked pending lines against the lines already being serviced. It raises the interrupt output only when a waiting line outranks everything in service, so a more urgent request can nest over a less urgent one.

The processor answers with two acknowledge strobes. The first one moves the winning line from pending to in-service. After the second one, the block presents an 8-bit vector for one cycle. The vector is an 8-aligned base with the line number in its low three bits. In-service bits stay set until software writes an end-of-interrupt command, which retires the most urgent in-service line.

One instance can run as a master with a second controller hanging off one of its inputs. When that input is acknowledged, the master signals the slave and stays silent on the vector bus. An instance can also run as a slave, which answers acknowledges only while it is selected.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no interrupt is requested, no vector is valid, the vector output is zero, nothing is pending or in service, and every line is masked.
- R2: A line becomes pending on a low-to-high transition, and `intReq` can respond after the next clock edge. A line that stays high does not become pending again until it has returned low.
- R3: Register 1 is the mask, where bit i = 1 blocks line i. A masked pending line is never reported but stays latched, and it is reported once it is unmasked.
- R4: Priority is fixed, with line 0 most urgent and line 7 least urgent. The first acknowledge picks the most urgent unmasked pending line.
- R5: `intReq` is high exactly when some unmasked pending line is more urgent than every in-service line, or when nothing is in service and some unmasked line is pending.
- R6: Register 0 holds the vector base, and its low three bits are forced to zero on write. In the cycle after the second acknowledge strobe, `vecValid` is high for one cycle and `vecOut` equals base OR the acknowledged line number.
- R7: The first acknowledge strobe sets the chosen line's in-service bit and clears its pending bit. In-service bits never get set at any other time.
- R8: A write to register 3 (end of interrupt, data ignored) clears the most urgent in-service bit. With nothing in service, the write has no effect.
- R9: If no line qualifies at the first acknowledge, the vector after the second strobe is base OR 7, and the in-service state does not change.
- R10: Register 2 bit 0 selects master mode, and bits 4:2 give the cascade input. If the acknowledged line is the cascade input, `casGrant` is high during both strobes and `vecValid` stays low.
- R11: Register 2 bit 1 selects slave mode. In that mode acknowledge strobes are ignored while `casSel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Peripheral request lines, edge sensitive |
| ackStb | input | 1 | One-cycle acknowledge strobe from the processor |
| casSel | input | 1 | Slave select from a master |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 base, 1 mask, 2 config, 3 end of interrupt |
| wrData | input | 8 | Register write data |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector presented after the second acknowledge |
| vecValid | output | 1 | Qualifies vecOut for one cycle |
| casGrant | output | 1 | Master tells the slave to answer this acknowledge |

## Verification
Several rules are checked on every cycle. The interrupt output never rises without an unmasked pending line behind it. In-service bits appear only after an acknowledge strobe. An end-of-interrupt write retires at most one in-service bit. A valid vector lasts one cycle and always follows a strobe. Other behaviour only shows up in the bench scenarios, because those checks need an independent model of the pending and in-service sets: which line wins, whether a nested request is refused, the vector value, spurious acknowledges, silence on a held-high line, and the cascade and slave handshakes.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int IRQ_COUNT = 8;
  localparam int IDX_W = $clog2(IRQ_COUNT);
  localparam int VEC_W = 8;
  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    REG_BASE = 2'd0,
    REG_MASK = 2'd1,
    REG_CFG  = 2'd2,
    REG_EOI  = 2'd3
  } reg_addr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             grant;
    logic [IDX_W-1:0] grantIdx;
    logic             eoi;
    logic             vecLoad;
    logic [IDX_W-1:0] vecIdx;
  } strobe_t;

  // returns {found, index of lowest set bit}
  function automatic logic [IDX_W:0] lowestSet(input logic [IRQ_COUNT-1:0] v);
    logic [IDX_W:0] res;
    res = '0;
    for (int i = IRQ_COUNT - 1; i >= 0; i--) begin
      if (v[i]) res = {1'b1, IDX_W'(i)};
    end
    return res;
  endfunction
endpackage

// File: rtl/prio_irq_dp.sv
module prio_irq_dp
  import prio_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRQ_COUNT-1:0] irqIn,
  input  logic                 wrEn,
  input  logic [1:0]           wrAddr,
  input  logic [7:0]           wrData,
  input  strobe_t              stb,
  output logic [IRQ_COUNT-1:0] irrQ,
  output logic [IRQ_COUNT-1:0] isrQ,
  output logic [IRQ_COUNT-1:0] imrQ,
  output logic [VEC_W-1:0]     baseQ,
  output logic [CFG_W-1:0]     cfgQ,
  output logic                 winValid,
  output logic [IDX_W-1:0]     winIdx,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);
  logic [IRQ_COUNT-1:0] irqPrev;
  logic [IRQ_COUNT-1:0] rise;
  logic [IRQ_COUNT-1:0] elig;
  logic [IRQ_COUNT-1:0] grantMask;
  logic [IRQ_COUNT-1:0] eoiMask;
  logic [IDX_W:0]       eligEnc;
  logic [IDX_W:0]       isrEnc;

  // per-line transition detect
  for (genvar g = 0; g < IRQ_COUNT; g++) begin : g_edge
    assign rise[g] = irqIn[g] & ~irqPrev[g];
  end

  assign elig    = irrQ & ~imrQ;
  assign eligEnc = lowestSet(elig);
  assign isrEnc  = lowestSet(isrQ);
  assign winIdx  = eligEnc[IDX_W-1:0];
  assign winValid = eligEnc[IDX_W] &&
                    (!isrEnc[IDX_W] || (eligEnc[IDX_W-1:0] < isrEnc[IDX_W-1:0]));

  always_comb begin
    grantMask = '0;
    eoiMask   = '0;
    if (stb.grant) grantMask[stb.grantIdx] = 1'b1;
    if (stb.eoi && isrEnc[IDX_W]) eoiMask[isrEnc[IDX_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev  <= '0;
      irrQ     <= '0;
      isrQ     <= '0;
      imrQ     <= '1;
      baseQ    <= '0;
      cfgQ     <= '0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      irqPrev  <= irqIn;
      irrQ     <= (irrQ & ~grantMask) | rise;
      isrQ     <= (isrQ & ~eoiMask) | grantMask;
      vecValid <= stb.vecLoad;
      if (stb.vecLoad) vecOut <= baseQ | VEC_W'(stb.vecIdx);
      if (wrEn) begin
        case (reg_addr_e'(wrAddr))
          REG_BASE: baseQ <= {wrData[VEC_W-1:IDX_W], {IDX_W{1'b0}}};
          REG_MASK: imrQ  <= wrData[IRQ_COUNT-1:0];
          REG_CFG:  cfgQ  <= wrData[CFG_W-1:0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ackStb,
  input  logic             casSel,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CFG_W-1:0] cfgQ,
  input  logic             winValid,
  input  logic [IDX_W-1:0] winIdx,
  output strobe_t          stb,
  output logic             casGrant
);
  typedef enum logic {PH_FIRST, PH_SECOND} phase_e;

  phase_e           phase;
  logic [IDX_W-1:0] ackIdx;
  logic             ackCas;
  logic             masterCas;
  logic             slaveMode;
  logic [IDX_W-1:0] casIdx;
  logic             take;
  logic             firstCas;

  assign masterCas = cfgQ[0];
  assign slaveMode = cfgQ[1];
  assign casIdx    = cfgQ[2 +: IDX_W];
  assign take      = ackStb && (!slaveMode || casSel);
  assign firstCas  = masterCas && winValid && (winIdx == casIdx);

  always_comb begin
    stb          = '0;
    stb.eoi      = wrEn && (reg_addr_e'(wrAddr) == REG_EOI);
    stb.grantIdx = winIdx;
    stb.vecIdx   = ackIdx;
    if (take && phase == PH_FIRST)  stb.grant   = winValid;
    if (take && phase == PH_SECOND) stb.vecLoad = !ackCas;
  end

  assign casGrant = take && ((phase == PH_FIRST && firstCas) ||
                             (phase == PH_SECOND && ackCas));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_FIRST;
      ackIdx <= '0;
      ackCas <= 1'b0;
    end else if (take) begin
      if (phase == PH_FIRST) begin
        phase  <= PH_SECOND;
        ackIdx <= winValid ? winIdx : '1;
        ackCas <= firstCas;
      end else begin
        phase  <= PH_FIRST;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] irqIn,
  input  logic       ackStb,
  input  logic       casSel,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       intReq,
  output logic [7:0] vecOut,
  output logic       vecValid,
  output logic       casGrant
);
  strobe_t              stb;
  logic [IRQ_COUNT-1:0] irrQ;
  logic [IRQ_COUNT-1:0] isrQ;
  logic [IRQ_COUNT-1:0] imrQ;
  logic [VEC_W-1:0]     baseQ;
  logic [CFG_W-1:0]     cfgQ;
  logic                 winValid;
  logic [IDX_W-1:0]     winIdx;

  prio_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .stb(stb), .irrQ(irrQ), .isrQ(isrQ), .imrQ(imrQ),
    .baseQ(baseQ), .cfgQ(cfgQ), .winValid(winValid), .winIdx(winIdx),
    .vecOut(vecOut), .vecValid(vecValid)
  );

  prio_irq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .ackStb(ackStb), .casSel(casSel), .wrEn(wrEn),
    .wrAddr(wrAddr), .cfgQ(cfgQ), .winValid(winValid), .winIdx(winIdx),
    .stb(stb), .casGrant(casGrant)
  );

  assign intReq = winValid;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ackStb,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic       intReq,
  input logic       vecValid,
  input logic [7:0] irrQ,
  input logic [7:0] isrQ,
  input logic [7:0] imrQ
);
  // R3
  req_has_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> ((irrQ & ~imrQ) != 8'h00));

  // R6
  vec_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  // R6
  vec_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(ackStb));

  // R7
  isr_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ackStb |=> ((isrQ & ~$past(isrQ)) == 8'h00));

  // R8
  eoi_retires_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3 && !ackStb) |=>
      (($countones(isrQ) + (($past(isrQ) != 8'h00) ? 1 : 0)) == $countones($past(isrQ))));
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .ackStb(ackStb), .wrEn(wrEn), .wrAddr(wrAddr),
  .intReq(intReq), .vecValid(vecValid), .irrQ(irrQ), .isrQ(isrQ), .imrQ(imrQ)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       ackStb = 1'b0;
  logic       casSel = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       intReq;
  logic [7:0] vecOut;
  logic       vecValid;
  logic       casGrant;

  int errs = 0;
  int checks = 0;

  logic [7:0] mIrr = '0, mIsr = '0, mImr = 8'hFF, mBase = '0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ackStb(ackStb), .casSel(casSel),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .intReq(intReq),
    .vecOut(vecOut), .vecValid(vecValid), .casGrant(casGrant)
  );

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit mInt();
    logic [7:0] e;
    e = mIrr & ~mImr;
    return (e != 0) && (mIsr == 0 || lowest(e) < lowest(mIsr));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      2'd0: mBase = {d[7:3], 3'b000};
      2'd1: mImr = d;
      2'd3: if (mIsr != 0) mIsr[lowest(mIsr)] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic pulseIrq(input logic [7:0] b);
    irqIn = b;
    @(negedge clk);
    irqIn = '0;
    @(negedge clk);
    mIrr |= b;
  endtask

  task automatic doAck(input logic sel, output logic [7:0] v, output logic vv,
                       output logic g1, output logic g2);
    casSel = sel; ackStb = 1'b1;
    #1 g1 = casGrant;
    @(negedge clk);
    ackStb = 1'b0;
    @(negedge clk);
    ackStb = 1'b1;
    #1 g2 = casGrant;
    @(negedge clk);
    ackStb = 1'b0; casSel = 1'b0;
    vv = vecValid; v = vecOut;
  endtask

  task automatic checkInt(input string tag);
    chk(intReq == mInt(), tag, intReq, mInt());
  endtask

  task automatic ackCheck(input string tag);
    logic [7:0] v; logic vv, g1, g2; int idx; bit hit;
    hit = mInt();
    idx = hit ? lowest(mIrr & ~mImr) : 7;
    doAck(1'b0, v, vv, g1, g2);
    chk(vv == 1'b1, {tag, " valid"}, vv, 1);
    chk(v == (mBase | 8'(idx)), {tag, " vector"}, v, mBase | 8'(idx));
    if (hit) begin
      mIsr[idx] = 1'b1;
      mIrr[idx] = 1'b0;
    end
    checkInt({tag, " intReq after ack"});
  endtask

  initial begin
    #(4 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] v; logic vv, g1, g2;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(intReq == 0, "R1 intReq", intReq, 0);
    chk(vecValid == 0, "R1 vecValid", vecValid, 0);
    chk(vecOut == 0, "R1 vecOut", vecOut, 0);

    wrReg(2'd0, 8'h4D);  // R6 base low bits dropped -> 0x48
    // R3 masked line latches but is silent
    pulseIrq(8'h10);
    chk(intReq == 0, "R3 masked silent", intReq, 0);
    wrReg(2'd1, 8'h00);
    chk(intReq == 1, "R3 unmasked reported", intReq, 1);
    ackCheck("R6 R7 line4");
    wrReg(2'd3, 8'h00);

    // R4 priority, R5 nesting, R8 eoi order
    pulseIrq(8'h28);
    ackCheck("R4 line3 wins");
    checkInt("R5 lower blocked");
    chk(intReq == 0, "R5 line5 under line3", intReq, 0);
    pulseIrq(8'h02);
    chk(intReq == 1, "R5 nest line1", intReq, 1);
    ackCheck("R5 nested ack");
    wrReg(2'd3, 8'h00);
    checkInt("R8 eoi clears line1");
    wrReg(2'd3, 8'h00);
    chk(intReq == 1, "R8 eoi clears line3", intReq, 1);
    ackCheck("R4 line5");
    wrReg(2'd3, 8'h00);
    wrReg(2'd3, 8'h00);  // R8 nothing in service: ignored
    checkInt("R8 empty eoi");
    pulseIrq(8'h40);
    ackCheck("R8 state intact after empty eoi");
    wrReg(2'd3, 8'h00);

    // R9 spurious
    ackCheck("R9 spurious");
    chk(intReq == 0, "R9 no change", intReq, 0);

    // R2 held-high line
    irqIn = 8'h01;
    @(negedge clk);
    mIrr[0] = 1'b1;
    chk(intReq == 1, "R2 edge seen", intReq, 1);
    ackCheck("R2 ack line0");
    wrReg(2'd3, 8'h00);
    chk(intReq == 0, "R2 held high no retrigger", intReq, 0);
    irqIn = 8'h00;
    @(negedge clk);
    irqIn = 8'h01;
    @(negedge clk);
    mIrr[0] = 1'b1;
    chk(intReq == 1, "R2 new edge", intReq, 1);
    ackCheck("R2 second ack");
    wrReg(2'd3, 8'h00);
    irqIn = 8'h00;
    @(negedge clk);

    // random mix against the model
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: pulseIrq(8'($urandom));
        1: ackCheck("R4 R6 random ack");
        2: wrReg(2'd3, 8'h00);
        default: wrReg(2'd1, 8'($urandom & $urandom));
      endcase
      checkInt("R5 random");
    end

    // R10 master cascade on line 2
    wrReg(2'd1, 8'hFF);
    repeat (8) wrReg(2'd3, 8'h00);
    wrReg(2'd2, 8'h09);
    wrReg(2'd1, 8'hFB);
    pulseIrq(8'h04);
    chk(intReq == 1, "R10 cascade line pending", intReq, 1);
    doAck(1'b0, v, vv, g1, g2);
    mIsr[2] = 1'b1; mIrr[2] = 1'b0;
    chk(g1 == 1, "R10 grant first strobe", g1, 1);
    chk(g2 == 1, "R10 grant second strobe", g2, 1);
    chk(vv == 0, "R10 master silent", vv, 0);
    wrReg(2'd3, 8'h00);

    // R11 slave mode
    wrReg(2'd2, 8'h02);
    wrReg(2'd1, 8'hDF);
    pulseIrq(8'h20);
    doAck(1'b0, v, vv, g1, g2);
    chk(vv == 0, "R11 unselected ignored", vv, 0);
    chk(intReq == 1, "R11 request still pending", intReq, 1);
    doAck(1'b1, v, vv, g1, g2);
    chk(vv == 1, "R11 selected valid", vv, 1);
    chk(v == (mBase | 8'h05), "R11 selected vector", v, mBase | 8'h05);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule